// File: doc/BRIEF.md
# Page Access Permission Checker

This unit decides whether one translated memory access may proceed. It takes the attributes of the segment being accessed, the current privilege level, the protection bits of the page-table entry that matched, and the kind of access: instruction fetch, load or store. From these it derives an effective protection key and a no-execute flag. It then works out read, write and execute rights for the page and returns one of three results: grant, protection fault, or not-translated. It also returns the rights vector and the key it used.

Two entry layouts are handled, selected per request by `wide_mode`. The narrow layout takes its segment fields from a 32-bit segment word and uses a 2-bit page protection code. The wide layout takes its segment fields from an 8-bit attribute byte and uses a 3-bit protection code. In the wide layout, page-level no-execute and guarded bits also remove execute rights.

Table search, address formation and translation caching are done elsewhere. The unit takes one request per cycle and returns each answer exactly one clock later.

Top module: `page_prot_chk`

## Requirements
- R1: When `in_valid` is high at a clock edge, `out_valid` is high for the following cycle with the answer for that request. In a cycle after an edge without `in_valid`, `out_valid`, `result`, `perm` and `eff_key` are all 0. After reset all outputs are 0.
- R2: The effective key is 1 when the user-key bit is set and `user_mode` is 1, or when the supervisor-key bit is set and `user_mode` is 0; otherwise it is 0. In narrow mode the supervisor-key bit is `seg_desc[30]` and the user-key bit is `seg_desc[29]`. In wide mode they are `seg_attr[7]` and `seg_attr[6]`. The key is reported on `eff_key`.
- R3: With key 0, protection codes 0, 1 and 2 give read and write. Codes 3 and 6 give read only. Codes 4, 5 and 7 give nothing. `perm` bit 0 is read, bit 1 is write and bit 2 is execute.
- R4: With key 1, codes 1 and 3 give read only and code 2 gives read and write. Codes 0, 4, 5, 6 and 7 give nothing.
- R5: In wide mode the protection code is {`pte_word[63]`, `pte_word[1:0]`}. In narrow mode it is {0, `pte_word[1:0]`}, so bit 63 has no effect there.
- R6: Execute right is 1 exactly when the combined no-execute flag is 0. In narrow mode that flag is `seg_desc[28]`. In wide mode it is `seg_attr[5]` OR `pte_word[2]` (page no-execute) OR `pte_word[3]` (guarded). In narrow mode `pte_word[3:2]` have no effect.
- R7: `acc_type` 0 is a fetch and is checked against execute. `acc_type` 2 is a store and is checked against write. `acc_type` 1 and 3 are loads and are checked against read. A held right gives `result` 01 (grant); a missing right gives 10 (fault).
- R8: In narrow mode, when `seg_desc[31]` (direct-store segment) is set, `result` is 11 (not-translated) and `perm` is 000 for every access type. In wide mode `seg_desc` has no effect.
- R9: A fetch from a segment whose segment-level no-execute bit is set gives `result` 11 and `perm` 000, not a fault. Loads and stores to such a segment are checked normally, with execute right 0. A fetch denied only by page-level no-execute or guarded bits gives a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| wide_mode | input | 1 | 1 selects the wide entry layout, 0 the narrow one |
| user_mode | input | 1 | 1 when the processor runs in user state |
| seg_desc | input | SEG_W (32) | Narrow-layout segment word |
| seg_attr | input | ATTR_W (8) | Wide-layout segment attribute byte |
| pte_word | input | ENTRY_W (64) | Protection word of the matching page entry |
| acc_type | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| out_valid | output | 1 | Answer strobe, one cycle after the request |
| result | output | 2 | 00 none, 01 grant, 10 fault, 11 not-translated |
| perm | output | 3 | {execute, write, read} rights |
| eff_key | output | 1 | Effective protection key used |

## Verification
The answer register holds a single request, so a fault in the unit shows at the ports on the cycle right after the request that exposes it. A wrong key or a wrong table entry shows as a wrong `perm` or `eff_key` for one specific combination of key, code and mode. For that reason every code is driven under both keys and both layouts. A mix-up between the miss and fault paths, for example on segment-level versus page-level no-execute, shows only as the `result` value, because `perm` is zero in the miss case. The bench therefore drives both paths with fetch, load and store. A stale-data fault shows on the cycle after an idle edge.

// File: rtl/prot_chk_pkg.sv
package prot_chk_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_LOAD2 = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_GRANT = 2'd1,
        RES_FAULT = 2'd2,
        RES_MISS  = 2'd3
    } res_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef struct packed {
        logic key;
        logic direct;
        logic seg_nx;
    } seg_info_t;

    // Read/write rights for a protection code under a given key.
    // Execute is decided separately.
    function automatic perm_t code_rights(input logic key, input logic [CODE_W-1:0] code);
        perm_t p;
        p = '0;
        if (!key) begin
            case (code)
                3'd0, 3'd1, 3'd2: begin p.r = 1'b1; p.w = 1'b1; end
                3'd3, 3'd6:       p.r = 1'b1;
                default:          ;
            endcase
        end else begin
            case (code)
                3'd1, 3'd3: p.r = 1'b1;
                3'd2:       begin p.r = 1'b1; p.w = 1'b1; end
                default:    ;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/prot_seg_decode.sv
module prot_seg_decode
    import prot_chk_pkg::*;
#(
    parameter int SEG_W  = 32,
    parameter int ATTR_W = 8
) (
    input  logic              wide_mode,
    input  logic              user_mode,
    input  logic [SEG_W-1:0]  seg_desc,
    input  logic [ATTR_W-1:0] seg_attr,
    output seg_info_t         info
);
    // Narrow layout: top four bits of the segment word.
    localparam int S_DS = SEG_W - 1;
    localparam int S_SK = SEG_W - 2;
    localparam int S_UK = SEG_W - 3;
    localparam int S_NX = SEG_W - 4;
    // Wide layout: top three bits of the attribute byte.
    localparam int A_SK = ATTR_W - 1;
    localparam int A_UK = ATTR_W - 2;
    localparam int A_NX = ATTR_W - 3;

    logic unused_seg_bits;
    assign unused_seg_bits = ^{seg_desc[S_NX-1:0], seg_attr[A_NX-1:0]};

    always_comb begin
        if (wide_mode) begin
            info.key    = (seg_attr[A_UK] & user_mode) | (seg_attr[A_SK] & ~user_mode);
            info.direct = 1'b0;
            info.seg_nx = seg_attr[A_NX];
        end else begin
            info.key    = (seg_desc[S_UK] & user_mode) | (seg_desc[S_SK] & ~user_mode);
            info.direct = seg_desc[S_DS];
            info.seg_nx = seg_desc[S_NX];
        end
    end
endmodule

// File: rtl/prot_rights.sv
module prot_rights
    import prot_chk_pkg::*;
#(
    parameter int ENTRY_W = 64
) (
    input  logic               wide_mode,
    input  logic               key,
    input  logic               seg_nx,
    input  logic [ENTRY_W-1:0] pte_word,
    output perm_t              rights
);
    localparam int P_HI = ENTRY_W - 1;
    localparam int P_NX = 2;
    localparam int P_G  = 3;

    logic unused_pte_bits;
    assign unused_pte_bits = ^pte_word[P_HI-1:P_G+1];

    logic [CODE_W-1:0] code;
    logic              nx_all;
    perm_t             rw;

    always_comb begin
        if (wide_mode) begin
            code   = {pte_word[P_HI], pte_word[1:0]};
            nx_all = seg_nx | pte_word[P_NX] | pte_word[P_G];
        end else begin
            code   = {1'b0, pte_word[1:0]};
            nx_all = seg_nx;
        end
        rw       = code_rights(key, code);
        rights.r = rw.r;
        rights.w = rw.w;
        rights.x = ~nx_all;
    end
endmodule

// File: rtl/prot_verdict.sv
module prot_verdict
    import prot_chk_pkg::*;
(
    input  seg_info_t  info,
    input  perm_t      rights,
    input  logic [1:0] acc_type,
    output res_e       res,
    output perm_t      perm_out
);
    acc_e acc;
    logic need;

    always_comb begin
        acc      = acc_e'(acc_type);
        perm_out = rights;
        case (acc)
            ACC_FETCH: need = rights.x;
            ACC_STORE: need = rights.w;
            default:   need = rights.r;
        endcase
        if (info.direct || (acc == ACC_FETCH && info.seg_nx)) begin
            res      = RES_MISS;
            perm_out = '0;
        end else begin
            res = need ? RES_GRANT : RES_FAULT;
        end
    end
endmodule

// File: rtl/page_prot_chk.sv
module page_prot_chk
    import prot_chk_pkg::*;
#(
    parameter int SEG_W   = 32,
    parameter int ATTR_W  = 8,
    parameter int ENTRY_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               wide_mode,
    input  logic               user_mode,
    input  logic [SEG_W-1:0]   seg_desc,
    input  logic [ATTR_W-1:0]  seg_attr,
    input  logic [ENTRY_W-1:0] pte_word,
    input  logic [1:0]         acc_type,
    output logic               out_valid,
    output logic [1:0]         result,
    output logic [2:0]         perm,
    output logic               eff_key
);
    seg_info_t info;
    perm_t     rights;
    perm_t     perm_n;
    res_e      res_n;

    prot_seg_decode #(.SEG_W(SEG_W), .ATTR_W(ATTR_W)) u_seg (
        .wide_mode (wide_mode),
        .user_mode (user_mode),
        .seg_desc  (seg_desc),
        .seg_attr  (seg_attr),
        .info      (info)
    );

    prot_rights #(.ENTRY_W(ENTRY_W)) u_rights (
        .wide_mode (wide_mode),
        .key       (info.key),
        .seg_nx    (info.seg_nx),
        .pte_word  (pte_word),
        .rights    (rights)
    );

    prot_verdict u_verdict (
        .info     (info),
        .rights   (rights),
        .acc_type (acc_type),
        .res      (res_n),
        .perm_out (perm_n)
    );

    always_ff @(posedge clk) begin
        if (rst || !in_valid) begin
            out_valid <= 1'b0;
            result    <= RES_NONE;
            perm      <= '0;
            eff_key   <= 1'b0;
        end else begin
            out_valid <= 1'b1;
            result    <= res_n;
            perm      <= perm_n;
            eff_key   <= info.key;
        end
    end
endmodule

// File: rtl/page_prot_chk_sva.sv
module page_prot_chk_sva (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       wide_mode,
    input logic       ds_bit,
    input logic [1:0] pte_nxg,
    input logic [1:0] acc_type,
    input logic       out_valid,
    input logic [1:0] result,
    input logic [2:0] perm
);
    // R1
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && result == 2'b00 && perm == 3'b000));

    // R8
    ds_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide_mode && ds_bit) |=> (result == 2'b11 && perm == 3'b000));

    // R6
    page_nx_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wide_mode && pte_nxg != 2'b00) |=> !perm[2]);

    // R7
    fetch_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && acc_type == 2'd0) |=> (result != 2'b01 || perm[2]));

    // R7
    store_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && acc_type == 2'd2) |=> (result != 2'b01 || perm[1]));

    // R9
    miss_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (result == 2'b11) |-> (perm == 3'b000 && out_valid));
endmodule

bind page_prot_chk page_prot_chk_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .wide_mode (wide_mode),
    .ds_bit    (seg_desc[SEG_W-1]),
    .pte_nxg   (pte_word[3:2]),
    .acc_type  (acc_type),
    .out_valid (out_valid),
    .result    (result),
    .perm      (perm)
);

// File: tb/page_prot_chk_tb.sv
module page_prot_chk_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        wide_mode = 1'b0;
    logic        user_mode = 1'b0;
    logic [31:0] seg_desc = '0;
    logic [7:0]  seg_attr = '0;
    logic [63:0] pte_word = '0;
    logic [1:0]  acc_type = '0;
    logic        out_valid;
    logic [1:0]  result;
    logic [2:0]  perm;
    logic        eff_key;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [6:0] exp_v = '0;
    string      exp_tag = "R1";

    always #10 clk = ~clk;

    page_prot_chk u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .wide_mode(wide_mode),
        .user_mode(user_mode), .seg_desc(seg_desc), .seg_attr(seg_attr),
        .pte_word(pte_word), .acc_type(acc_type), .out_valid(out_valid),
        .result(result), .perm(perm), .eff_key(eff_key)
    );

    // Behavioural reference: {valid, result[1:0], x, w, r, key}
    function automatic logic [6:0] model(bit w, bit u, logic [31:0] s, logic [7:0] a,
                                         logic [63:0] p, int t);
        int  key, code;
        bit  ds, snx, nx, rd, wr, ok;
        if (w) begin
            key  = ((a[7] && !u) || (a[6] && u)) ? 1 : 0;
            ds   = 0;
            snx  = a[5];
            code = int'(p[1:0]) + (p[63] ? 4 : 0);
            nx   = snx || p[2] || p[3];
        end else begin
            key  = ((s[30] && !u) || (s[29] && u)) ? 1 : 0;
            ds   = s[31];
            snx  = s[28];
            code = int'(p[1:0]);
            nx   = snx;
        end
        if (key == 0) begin
            rd = (code <= 3) || (code == 6);
            wr = (code <= 2);
        end else begin
            rd = (code >= 1) && (code <= 3);
            wr = (code == 2);
        end
        if (ds || (t == 0 && snx))
            return {1'b1, 2'b11, 3'b000, key[0]};
        if (t == 0)      ok = !nx;
        else if (t == 2) ok = wr;
        else             ok = rd;
        return {1'b1, (ok ? 2'b01 : 2'b10), !nx, wr, rd, key[0]};
    endfunction

    task automatic compare();
        logic [6:0] got;
        got = {out_valid, result, perm, eff_key};
        checks++;
        if (got !== exp_v) begin
            errors++;
            $display("FAIL %s: got v=%0b res=%02b perm=%03b key=%0b expected v=%0b res=%02b perm=%03b key=%0b",
                     exp_tag, got[6], got[5:4], got[3:1], got[0],
                     exp_v[6], exp_v[5:4], exp_v[3:1], exp_v[0]);
        end
    endtask

    task automatic step(bit v, bit w, bit u, logic [31:0] s, logic [7:0] a,
                        logic [63:0] p, logic [1:0] t, string tag);
        @(negedge clk);
        compare();
        in_valid  = v;
        wide_mode = w;
        user_mode = u;
        seg_desc  = s;
        seg_attr  = a;
        pte_word  = p;
        acc_type  = t;
        exp_v     = v ? model(w, u, s, a, p, int'(t)) : 7'd0;
        exp_tag   = tag;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: got hung run expected completion");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state checked by the first compare
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        // R2 key derivation, narrow then wide
        step(1, 0, 0, 32'h4000_0000, 0, 64'h2, 1, "R2");
        step(1, 0, 1, 32'h4000_0000, 0, 64'h2, 1, "R2");
        step(1, 0, 1, 32'h2000_0000, 0, 64'h0, 1, "R2");
        step(1, 0, 0, 32'h2000_0000, 0, 64'h0, 1, "R2");
        step(1, 1, 0, 0, 8'h80, 64'h0, 1, "R2");
        step(1, 1, 1, 0, 8'h40, 64'h0, 1, "R2");
        step(1, 1, 0, 0, 8'h40, 64'h0, 1, "R2");
        // R1 idle gap
        step(0, 0, 0, 0, 0, 0, 1, "R1");
        // R3 every code under key 0, load and store
        for (int c = 0; c < 8; c++) begin
            step(1, 1, 0, 0, 8'h00, {c[2], 61'd0, c[1:0]}, 1, "R3");
            step(1, 1, 0, 0, 8'h00, {c[2], 61'd0, c[1:0]}, 2, "R3");
        end
        // R4 every code under key 1
        for (int c = 0; c < 8; c++) begin
            step(1, 1, 0, 0, 8'h80, {c[2], 61'd0, c[1:0]}, 1, "R4");
            step(1, 1, 0, 0, 8'h80, {c[2], 61'd0, c[1:0]}, 2, "R4");
        end
        // R5 bit 63 counts only in wide mode
        step(1, 0, 0, 32'h4000_0000, 0, 64'h8000_0000_0000_0002, 2, "R5");
        step(1, 1, 0, 0, 8'h80, 64'h8000_0000_0000_0002, 1, "R5");
        step(1, 1, 0, 0, 8'h00, 64'h8000_0000_0000_0002, 2, "R5");
        // R6 execute merging
        step(1, 0, 0, 0, 0, 64'hC, 0, "R6");
        step(1, 1, 0, 0, 0, 64'h8, 0, "R6");
        step(1, 1, 0, 0, 0, 64'h4, 0, "R6");
        step(1, 1, 0, 0, 8'h20, 64'h0, 1, "R6");
        step(1, 1, 0, 0, 0, 64'h0, 0, "R6");
        // R7 access type selection, including code 3 as a load
        step(1, 0, 0, 32'h4000_0000, 0, 64'h3, 3, "R7");
        step(1, 0, 0, 32'h4000_0000, 0, 64'h3, 2, "R7");
        step(1, 0, 0, 32'h4000_0000, 0, 64'h0, 3, "R7");
        step(1, 0, 0, 32'h4000_0000, 0, 64'h0, 0, "R7");
        // R8 direct-store segment
        step(1, 0, 0, 32'h8000_0000, 0, 64'h0, 1, "R8");
        step(1, 0, 0, 32'h8000_0000, 0, 64'h0, 0, "R8");
        step(1, 1, 0, 32'h8000_0000, 0, 64'h0, 2, "R8");
        // R9 segment no-execute: fetch misses, data proceeds
        step(1, 0, 0, 32'h1000_0000, 0, 64'h0, 0, "R9");
        step(1, 0, 0, 32'h1000_0000, 0, 64'h0, 2, "R9");
        step(1, 1, 0, 0, 8'h20, 64'h0, 0, "R9");
        step(1, 1, 0, 0, 8'h00, 64'h4, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        // Mixed patterns, covering R2..R9 and R1 gaps
        for (int i = 0; i < 400; i++) begin
            logic [31:0] s;
            logic [63:0] p;
            s = $urandom;
            p = {$urandom, $urandom};
            step(($urandom % 4) != 0, $urandom % 2, $urandom % 2, s,
                 8'($urandom), p, 2'($urandom), "R7 mixed");
        end
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule